// File: doc/BRIEF.md
# Chained Memory-Indirect Address Walker

This block works out the effective address of an operand whose address is reached through a chain of memory-indirect steps, up to four of them. Each step has its own displacement and its own index-register value. The first step adds its displacement to its index value and reads the 32-bit word stored at that sum. Every later step adds its own displacement and index value to the word fetched by the step before it, and reads again. The word fetched by the final step is the operand's address. It is not the operand itself.

A decode stage places the step count and all the per-step terms on the inputs and pulses `start`. The block then issues one word read at a time over a request/valid port and waits for each reply before it forms the next address. It ends the walk with a one-cycle `done` strobe. A faulting read, or a step count that cannot be walked, ends the walk with `fault` raised together with `done`. All sums wrap modulo 2^32, and a carry out is dropped. A source operand and a destination operand each need their own walk, and the block performs them one after the other.

Top module: `indgen_addr_gen`

## Requirements
- R1: The first read address is (displacement of step 0 + index of step 0) mod 2^32. Step i uses bits [32*i+31:32*i] of `disp_flat` and of `idx_flat`.
- R2: For each step i > 0, the read address is (word fetched by step i-1 + displacement i + index i) mod 2^32.
- R3: A step count n from 1 to 4 performs exactly n reads. In the cycle after the reply to read n, `done` is high for one cycle, `ea_out` holds the word returned by that read, and `busy` drops.
- R4: `mem_req` is high for exactly one cycle per read, and at most one read is outstanding. The next read is requested in the cycle right after the reply to the previous one.
- R5: A reply carrying `mem_err` ends the walk with no further reads. In the next cycle `done` and `fault` are high and `ea_out` is 0.
- R6: A start with a step count of 0 or greater than 4 issues no read. It raises `done` and `fault` in the next cycle, sets `ea_out` to 0, and leaves `busy` low.
- R7: A start is accepted only while `busy` is low, which includes the cycle in which `done` is high. A start while `busy` is high is ignored. Step terms are captured only when a start is accepted, so later changes to them do not affect the walk in progress.
- R8: `mem_valid` is ignored while no read is outstanding. It produces no `done` and leaves `ea_out` unchanged.
- R9: While and after reset, `mem_req`, `busy`, `done` and `fault` are low and `ea_out` is 0.
- R10: `ea_out` changes only in a cycle where `done` is high, and `fault` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk when idle |
| level_cnt | input | 3 | Number of indirect steps, 1 to 4 |
| disp_flat | input | 128 | Per-step displacements, step i at [32*i+31:32*i] |
| idx_flat | input | 128 | Per-step index-register values, step i at [32*i+31:32*i] |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | 32 | Read address, valid while `mem_req` is high |
| mem_valid | input | 1 | Read reply strobe |
| mem_err | input | 1 | Reply reports an access error |
| mem_rdata | input | 32 | Word returned with the reply |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle end-of-walk strobe |
| fault | output | 1 | The walk ended in error, high only with `done` |
| ea_out | output | 32 | Resulting operand address |

## Verification
The hardest situations to reach from the ports are a read error in the middle of a chain and a start that arrives exactly in the `done` cycle. The bench's memory model works out every address of a chain in advance. To put an error at a chosen step, it flags the address of that step, which may be a middle one. A start in the `done` cycle is issued on the same clock in which the bench sees `done`. Further starts are sent mid-walk, with altered step terms, to confirm that they leave the walk in progress untouched.

// File: rtl/indgen_pkg.sv
package indgen_pkg;

    localparam int WORD_W     = 32;
    localparam int MAX_LEVELS = 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_ISSUE = 2'd1,
        WALK_WAIT  = 2'd2
    } walk_state_e;

    typedef struct packed {
        word_t disp;
        word_t idx;
    } level_term_t;

    function automatic word_t sum3(input word_t a, input word_t b, input word_t c);
        return a + b + c;
    endfunction

endpackage

// File: rtl/indgen_opnd_bank.sv
module indgen_opnd_bank
    import indgen_pkg::*;
#(
    parameter int LEVELS = MAX_LEVELS,
    localparam int SEL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [LEVELS*WORD_W-1:0] disp_flat,
    input  logic [LEVELS*WORD_W-1:0] idx_flat,
    input  logic [SEL_W-1:0]         sel,
    output level_term_t              term
);

    level_term_t term_q [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        always_ff @(posedge clk) begin
            if (rst) begin
                term_q[g] <= '0;
            end else if (load) begin
                term_q[g].disp <= disp_flat[g*WORD_W +: WORD_W];
                term_q[g].idx  <= idx_flat[g*WORD_W +: WORD_W];
            end
        end
    end

    assign term = term_q[sel];

endmodule

// File: rtl/indgen_addr_calc.sv
module indgen_addr_calc
    import indgen_pkg::*;
(
    input  level_term_t term,
    input  word_t       base,
    output word_t       addr
);

    assign addr = sum3(base, term.disp, term.idx);

endmodule

// File: rtl/indgen_seq.sv
module indgen_seq
    import indgen_pkg::*;
#(
    parameter int LEVELS = MAX_LEVELS,
    localparam int SEL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int CNT_W = $clog2(LEVELS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] level_cnt,
    input  logic             mem_valid,
    input  logic             mem_err,
    input  word_t            mem_rdata,
    output logic             load,
    output logic [SEL_W-1:0] sel,
    output word_t            base,
    output logic             mem_req,
    output logic             busy,
    output logic             done,
    output logic             fault,
    output word_t            ea
);

    walk_state_e      state_q;
    logic [SEL_W-1:0] lvl_q;
    logic [SEL_W-1:0] last_q;
    word_t            base_q;
    word_t            ea_q;
    logic             done_q;
    logic             fault_q;
    logic             cnt_ok;

    assign cnt_ok = (level_cnt != '0) && (level_cnt <= CNT_W'(LEVELS));
    assign load   = (state_q == WALK_IDLE) && start && cnt_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WALK_IDLE;
            lvl_q   <= '0;
            last_q  <= '0;
            base_q  <= '0;
            ea_q    <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            unique case (state_q)
                WALK_IDLE: begin
                    if (start) begin
                        if (cnt_ok) begin
                            state_q <= WALK_ISSUE;
                            lvl_q   <= '0;
                            last_q  <= SEL_W'(level_cnt - CNT_W'(1));
                            base_q  <= '0;
                        end else begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b1;
                            ea_q    <= '0;
                        end
                    end
                end
                WALK_ISSUE: begin
                    state_q <= WALK_WAIT;
                end
                WALK_WAIT: begin
                    if (mem_valid) begin
                        if (mem_err) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b1;
                            ea_q    <= '0;
                            state_q <= WALK_IDLE;
                        end else if (lvl_q == last_q) begin
                            done_q  <= 1'b1;
                            ea_q    <= mem_rdata;
                            state_q <= WALK_IDLE;
                        end else begin
                            base_q  <= mem_rdata;
                            lvl_q   <= lvl_q + 1'b1;
                            state_q <= WALK_ISSUE;
                        end
                    end
                end
                default: state_q <= WALK_IDLE;
            endcase
        end
    end

    assign sel     = lvl_q;
    assign base    = base_q;
    assign mem_req = (state_q == WALK_ISSUE);
    assign busy    = (state_q != WALK_IDLE);
    assign done    = done_q;
    assign fault   = fault_q;
    assign ea      = ea_q;

endmodule

// File: rtl/indgen_addr_gen.sv
module indgen_addr_gen
    import indgen_pkg::*;
#(
    parameter int LEVELS = MAX_LEVELS,
    localparam int SEL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int CNT_W = $clog2(LEVELS + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [CNT_W-1:0]         level_cnt,
    input  logic [LEVELS*WORD_W-1:0] disp_flat,
    input  logic [LEVELS*WORD_W-1:0] idx_flat,
    output logic                     mem_req,
    output logic [WORD_W-1:0]        mem_addr,
    input  logic                     mem_valid,
    input  logic                     mem_err,
    input  logic [WORD_W-1:0]        mem_rdata,
    output logic                     busy,
    output logic                     done,
    output logic                     fault,
    output logic [WORD_W-1:0]        ea_out
);

    logic             load;
    logic [SEL_W-1:0] sel;
    word_t            base;
    level_term_t      term;

    indgen_seq #(.LEVELS(LEVELS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .level_cnt (level_cnt),
        .mem_valid (mem_valid),
        .mem_err   (mem_err),
        .mem_rdata (mem_rdata),
        .load      (load),
        .sel       (sel),
        .base      (base),
        .mem_req   (mem_req),
        .busy      (busy),
        .done      (done),
        .fault     (fault),
        .ea        (ea_out)
    );

    indgen_opnd_bank #(.LEVELS(LEVELS)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .disp_flat (disp_flat),
        .idx_flat  (idx_flat),
        .sel       (sel),
        .term      (term)
    );

    indgen_addr_calc u_calc (
        .term (term),
        .base (base),
        .addr (mem_addr)
    );

endmodule

// File: rtl/indgen_chk.sv
module indgen_chk #(
    parameter int LEVELS = 4,
    localparam int CNT_W = $clog2(LEVELS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CNT_W-1:0] level_cnt,
    input logic             mem_req,
    input logic             mem_valid,
    input logic             busy,
    input logic             done,
    input logic             fault,
    input logic [31:0]      ea_out
);

    logic pend_q;
    logic cnt_good;

    assign cnt_good = (level_cnt != '0) && (level_cnt <= CNT_W'(LEVELS));

    always_ff @(posedge clk) begin
        if (rst)            pend_q <= 1'b0;
        else if (mem_req)   pend_q <= 1'b1;
        else if (mem_valid) pend_q <= 1'b0;
    end

    p_req_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    p_one_outstanding_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !pend_q);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);

    p_busy_end_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_fault_zero_ea_r5: assert property (@(posedge clk) disable iff (rst)
        fault |-> (ea_out == 32'd0));

    p_bad_count_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !cnt_good) |=> (done && fault && !busy && !mem_req));

    p_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && cnt_good) |=> (busy && mem_req));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    p_fault_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        fault |-> done);

    p_ea_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(ea_out));

endmodule

bind indgen_addr_gen indgen_chk #(.LEVELS(LEVELS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .level_cnt (level_cnt),
    .mem_req   (mem_req),
    .mem_valid (mem_valid),
    .busy      (busy),
    .done      (done),
    .fault     (fault),
    .ea_out    (ea_out)
);

// File: tb/indgen_addr_gen_tb.sv
module indgen_addr_gen_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [2:0]   level_cnt = '0;
    logic [127:0] disp_flat = '0;
    logic [127:0] idx_flat = '0;
    logic         mem_req;
    logic [31:0]  mem_addr;
    logic         mem_valid = 1'b0;
    logic         mem_err = 1'b0;
    logic [31:0]  mem_rdata = '0;
    logic         busy, done, fault;
    logic [31:0]  ea_out;

    always #10 clk = ~clk;

    indgen_addr_gen u_dut (
        .clk(clk), .rst(rst), .start(start), .level_cnt(level_cnt),
        .disp_flat(disp_flat), .idx_flat(idx_flat),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_err(mem_err), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fault(fault), .ea_out(ea_out)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h0019_660D) ^ 32'h3C6E_F35F ^ {a[15:0], a[31:16]};
    endfunction

    // memory responder
    int          lat = 0;
    int          rcnt = 0;
    logic        pend = 1'b0;
    logic [31:0] paddr = '0;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;
    logic        stray_req = 1'b0;

    always @(negedge clk) begin
        mem_valid = 1'b0;
        mem_err   = 1'b0;
        if (rst) begin
            pend = 1'b0;
        end else if (pend) begin
            if (rcnt == 0) begin
                mem_valid = 1'b1;
                mem_rdata = mem_word(paddr);
                mem_err   = err_en && (paddr == err_addr);
                pend      = 1'b0;
            end else begin
                rcnt--;
            end
        end else if (mem_req) begin
            pend  = 1'b1;
            rcnt  = lat;
            paddr = mem_addr;
        end
        if (stray_req) begin
            mem_valid = 1'b1;
            mem_rdata = 32'hDEAD_0001;
            stray_req = 1'b0;
        end
    end

    // behavioural reference model, advanced on every rising edge
    int          m_phase = 0;
    int          m_lvl = 0;
    int          m_cnt = 0;
    logic [31:0] m_base = '0;
    logic [31:0] m_ea = '0;
    logic        m_done = 1'b0;
    logic        m_fault = 1'b0;
    logic [31:0] m_disp [4];
    logic [31:0] m_idx  [4];

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_done = 0; m_fault = 0; m_ea = '0; m_base = '0; m_lvl = 0;
        end else begin
            m_done = 0; m_fault = 0;
            if (m_phase == 0) begin
                if (start) begin
                    if (level_cnt >= 1 && level_cnt <= 4) begin
                        for (int i = 0; i < 4; i++) begin
                            m_disp[i] = disp_flat[i*32 +: 32];
                            m_idx[i]  = idx_flat[i*32 +: 32];
                        end
                        m_cnt = int'(level_cnt); m_lvl = 0; m_base = '0; m_phase = 1;
                    end else begin
                        m_done = 1; m_fault = 1; m_ea = '0;
                    end
                end
            end else if (m_phase == 1) begin
                m_phase = 2;
            end else if (mem_valid) begin
                if (mem_err) begin
                    m_done = 1; m_fault = 1; m_ea = '0; m_phase = 0;
                end else if (m_lvl == m_cnt - 1) begin
                    m_done = 1; m_ea = mem_rdata; m_phase = 0;
                end else begin
                    m_base = mem_rdata; m_lvl++; m_phase = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R4 mem_req", 32'(mem_req), 32'(m_phase == 1));
            if (m_phase == 1)
                check((m_lvl == 0) ? "R1 mem_addr" : "R2 mem_addr", mem_addr,
                      m_base + m_disp[m_lvl] + m_idx[m_lvl]);
            check("R3 done", 32'(done), 32'(m_done));
            check("R5 fault", 32'(fault), 32'(m_fault));
            check("R10 ea_out", ea_out, m_ea);
            check("R7 busy", 32'(busy), 32'(m_phase != 0));
        end
    end

    // independent chain walk
    logic [31:0] d_in [4];
    logic [31:0] r_in [4];

    function automatic logic [31:0] chain_addr(input int n);
        logic [31:0] b = '0;
        for (int i = 0; i < n; i++) b = mem_word(b + d_in[i] + r_in[i]);
        return b + d_in[n] + r_in[n];
    endfunction

    task automatic expect_walk(input int n, output logic [31:0] ea, output logic flt);
        logic [31:0] b = '0;
        ea = '0; flt = 1'b0;
        if (n < 1 || n > 4) begin flt = 1'b1; return; end
        for (int i = 0; i < n; i++) begin
            logic [31:0] a = b + d_in[i] + r_in[i];
            if (err_en && a == err_addr) begin flt = 1'b1; ea = '0; return; end
            b = mem_word(a);
        end
        ea = b;
    endtask

    task automatic drive_terms(input int n);
        for (int i = 0; i < 4; i++) begin
            disp_flat[i*32 +: 32] = d_in[i];
            idx_flat[i*32 +: 32]  = r_in[i];
        end
        level_cnt = 3'(n);
    endtask

    task automatic run_chain(input string tag, input int n, input bit immediate);
        logic [31:0] exp_ea;
        logic        exp_f;
        int          k;
        expect_walk(n, exp_ea, exp_f);
        if (!immediate) @(negedge clk);
        drive_terms(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 500) begin @(negedge clk); k++; end
        check({tag, " done seen"}, 32'(done), 32'd1);
        check({tag, " ea_out"}, ea_out, exp_ea);
        check({tag, " fault"}, 32'(fault), 32'(exp_f));
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] hold;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 mem_req", 32'(mem_req), 0);
        check("R9 busy", 32'(busy), 0);
        check("R9 done", 32'(done), 0);
        check("R9 fault", 32'(fault), 0);
        check("R9 ea_out", ea_out, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 idle after reset", 32'({mem_req, busy, done, fault}), 0);

        // R1 R3: single step
        lat = 0;
        for (int i = 0; i < 4; i++) begin d_in[i] = 32'h100 * (i + 1); r_in[i] = 32'h10 + i; end
        run_chain("R1 R3 one step", 1, 0);

        // R2 R3 R4: four steps, slow memory
        lat = 2;
        d_in[0] = 32'h0000_1000; r_in[0] = 32'h0000_0044;
        d_in[1] = 32'h0003_0D40; r_in[1] = 32'h0000_0008;
        d_in[2] = 32'h0004_93E0; r_in[2] = 32'hFFFF_FFF0;
        d_in[3] = 32'h0006_1A80; r_in[3] = 32'h0000_C350;
        run_chain("R2 R4 four steps", 4, 0);

        // R2 wraparound sums
        lat = 1;
        d_in[0] = 32'hFFFF_FFFF; r_in[0] = 32'h0000_0005;
        d_in[1] = 32'hFFFF_FF00; r_in[1] = 32'hF000_0000;
        d_in[2] = 32'h8000_0000; r_in[2] = 32'h8000_0001;
        run_chain("R2 wrap two steps", 2, 0);
        run_chain("R2 wrap three steps", 3, 0);

        // R5 error at a middle step
        lat = 1;
        err_en = 1'b1; err_addr = chain_addr(2);
        run_chain("R5 error at step 2", 4, 0);
        err_en = 1'b1; err_addr = chain_addr(0);
        run_chain("R5 error at step 0", 3, 0);
        err_en = 1'b0;

        // R6 bad counts
        run_chain("R6 count 0", 0, 0);
        check("R6 busy low", 32'(busy), 0);
        run_chain("R6 count 5", 5, 0);
        run_chain("R6 count 7", 7, 0);

        // R7 start while busy, with changed terms
        lat = 3;
        for (int i = 0; i < 4; i++) begin d_in[i] = 32'h2000 + 32'(i); r_in[i] = 32'h40 * 32'(i); end
        begin
            logic [31:0] exp_ea;
            logic        exp_f;
            int          k;
            expect_walk(4, exp_ea, exp_f);
            @(negedge clk);
            drive_terms(4);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                disp_flat[i*32 +: 32] = 32'hABCD_0000;
                idx_flat[i*32 +: 32]  = 32'h1234;
            end
            level_cnt = 3'd1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            k = 0;
            while (!done && k < 500) begin @(negedge clk); k++; end
            check("R7 busy start ignored ea_out", ea_out, exp_ea);
            check("R7 busy start ignored fault", 32'(fault), 32'(exp_f));
        end

        // R7 start in the done cycle
        lat = 0;
        for (int i = 0; i < 4; i++) begin d_in[i] = 32'h3000 + 32'(i); r_in[i] = 32'h7 * 32'(i); end
        run_chain("R7 immediate restart", 2, 1);
        @(negedge clk);
        check("R7 restart busy", 32'(busy), 0);

        // R8 stray reply while idle
        hold = ea_out;
        @(posedge clk);
        #1 stray_req = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 stray no done", 32'(done), 0);
        check("R8 stray ea_out", ea_out, hold);
        check("R8 stray busy", 32'(busy), 0);

        // mixed patterns
        for (int t = 0; t < 30; t++) begin
            int n;
            n   = int'($urandom_range(1, 4));
            lat = int'($urandom_range(0, 3));
            for (int i = 0; i < 4; i++) begin d_in[i] = $urandom; r_in[i] = $urandom; end
            err_en = ($urandom_range(0, 4) == 0);
            err_addr = chain_addr(int'($urandom_range(0, n - 1)));
            run_chain("R3 mixed", n, (t % 3) == 0);
        end
        err_en = 1'b0;

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule